// File: doc/BRIEF.md
# Multiprocessor Address Filter for a 9-bit Serial Receiver

This block sits next to a 9-bit asynchronous serial receiver and decides whether each completed frame is handed to software. The receiver presents every finished frame for one clock cycle as a strobe, together with the eight data bits, the ninth bit and whether the stop bit was sampled high. When multiprocessor filtering is off, every frame is delivered. When it is on, only frames whose ninth bit is 1 and whose byte matches this node's individual address or its broadcast address raise the receive flag. All other frames are dropped without disturbing software.

Both addresses come from two registers: a node address and a per-bit mask. A mask bit of 0 makes that address bit don't-care. The individual address is the node address in the mask=1 positions only. The broadcast address is node OR mask, and a received byte must hold 1 in every position where that OR is 1. A suitable choice of mask lets a group of nodes share one broadcast address while each node stays separately addressable.

The block also keeps a sticky framing-error flag. That flag shares the top bit of the control register with a mode bit, and a view-select bit picks which of the two that bit exposes.

Top module: `mp_addr_filter`

## Requirements
- R1: After reset, every register (control at 0, node address at 1, mask at 2, auxiliary at 3, receive data at 4) reads 0x00 and `rxf_o` is 0.
- R2: With the filter enable (control bit 5) at 0, every frame sets the receive flag and stores its byte, whatever its ninth bit.
- R3: With the filter enable at 1, a frame whose ninth bit is 0 leaves the receive flag at 0 and leaves the data register unchanged.
- R4: With the filter enable at 1 and the ninth bit at 1, a byte equal to the node address in every position where the mask is 1 is delivered. A byte that differs there and also misses the broadcast address is dropped.
- R5: With the filter enable at 1 and the ninth bit at 1, a byte holding 1 in every position where (node OR mask) is 1 is delivered as a broadcast.
- R6: A frame whose stop bit is low sets the framing-error flag. The flag stays set through later frames and clears only when software writes 0 to control bit 7 while the view-select bit (auxiliary bit 0) is 1.
- R7: With view-select at 0, control bit 7 reads and writes a mode bit, and writes there leave the framing-error flag alone. With view-select at 1, control bit 7 reads the framing-error flag, and writes there leave the mode bit alone.
- R8: The receive flag (control bit 0, also on `rxf_o`) clears when software writes 0 to it. Writing 1 does not set it. A frame delivered in the same cycle as a clearing write leaves the flag set.
- R9: Control bit 1 reads the ninth bit of the most recently delivered frame.
- R10: Register writes and frame results become visible on `rdata_o` after the clock edge that samples them. Addresses 5 to 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register address for reads and writes |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for `addr_i` (combinational) |
| frm_vld_i | input | 1 | One-cycle strobe: a frame has completed |
| frm_byte_i | input | DW | Received data byte |
| frm_bit9_i | input | 1 | Received ninth bit |
| frm_stop_i | input | 1 | Stop bit was sampled high |
| rxf_o | output | 1 | Receive flag |

## Verification
The bench builds the block with its defaults, DW=8 and AW=3. With those values, hand-picked address and mask pairs can cover the individual-only, broadcast-only, both, and neither cases, along with the all-don't-care reset configuration. The 3-bit address reaches the unused locations 5 to 7. The directed part drives a clearing write and a delivered frame into the same cycle, and toggles the view-select bit around a framing error so that the mode bit and the error flag are each seen to survive writes aimed at the other.

// File: rtl/mp_addr_filter.sv
`timescale 1ns/1ps
module mp_addr_filter #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          frm_vld_i,
  input  logic [DW-1:0] frm_byte_i,
  input  logic          frm_bit9_i,
  input  logic          frm_stop_i,
  output logic          rxf_o
);
  localparam int TOP = DW - 1;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_NODE = AW'(1);
  localparam logic [AW-1:0] A_MASK = AW'(2);
  localparam logic [AW-1:0] A_AUX  = AW'(3);
  localparam logic [AW-1:0] A_DATA = AW'(4);

  logic mode0_q, mode1_q, mp_en_q, ferr_q, view_q, rxf_q, bit9_q;
  logic [DW-1:0] node_q, mask_q, data_q, bcast;
  logic wr_ctrl, hit_given, hit_bcast, deliver, unused_wbits;

  assign wr_ctrl   = wr_en_i && (addr_i == A_CTRL);
  assign bcast     = node_q | mask_q;
  assign hit_given = ((frm_byte_i ^ node_q) & mask_q) == '0;
  assign hit_bcast = (frm_byte_i & bcast) == bcast;
  assign deliver   = frm_vld_i && (!mp_en_q || (frm_bit9_i && (hit_given || hit_bcast)));
  assign rxf_o     = rxf_q;
  assign unused_wbits = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode0_q <= 1'b0;
      mode1_q <= 1'b0;
      mp_en_q <= 1'b0;
      view_q  <= 1'b0;
      node_q  <= '0;
      mask_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) begin
        if (!view_q) mode0_q <= wdata_i[TOP];
        mode1_q <= wdata_i[TOP-1];
        mp_en_q <= wdata_i[TOP-2];
      end
      if (addr_i == A_NODE) node_q <= wdata_i;
      if (addr_i == A_MASK) mask_q <= wdata_i;
      if (addr_i == A_AUX)  view_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    ferr_q <= 1'b0;
    else if (frm_vld_i && !frm_stop_i)             ferr_q <= 1'b1;
    else if (wr_ctrl && view_q && !wdata_i[TOP])   ferr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q  <= 1'b0;
      bit9_q <= 1'b0;
      data_q <= '0;
    end else if (deliver) begin
      rxf_q  <= 1'b1;
      bit9_q <= frm_bit9_i;
      data_q <= frm_byte_i;
    end else if (wr_ctrl && !wdata_i[0]) begin
      rxf_q  <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[TOP]   = view_q ? ferr_q : mode0_q;
        rdata_o[TOP-1] = mode1_q;
        rdata_o[TOP-2] = mp_en_q;
        rdata_o[1]     = bit9_q;
        rdata_o[0]     = rxf_q;
      end
      A_NODE:  rdata_o = node_q;
      A_MASK:  rdata_o = mask_q;
      A_AUX:   rdata_o[0] = view_q;
      A_DATA:  rdata_o = data_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

module mp_addr_filter_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          frm_vld_i,
  input logic [DW-1:0] frm_byte_i,
  input logic          frm_bit9_i,
  input logic          frm_stop_i,
  input logic [DW-1:0] node_q,
  input logic [DW-1:0] mask_q,
  input logic          mp_en_q,
  input logic          ferr_q,
  input logic          view_q,
  input logic          rxf_o
);
  AST_PASS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_i && !mp_en_q) |=> rxf_o); // R2
  AST_DROP_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_i && mp_en_q && !frm_bit9_i && !rxf_o) |=> !rxf_o); // R3
  AST_GIVEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_i && mp_en_q && frm_bit9_i && ((frm_byte_i & mask_q) == (node_q & mask_q))) |=> rxf_o); // R4
  AST_BCAST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_i && mp_en_q && frm_bit9_i && ((frm_byte_i | node_q | mask_q) == frm_byte_i)) |=> rxf_o); // R5
  AST_FERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld_i && !frm_stop_i) |=> ferr_q); // R6
  AST_FERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ferr_q && !(wr_en_i && addr_i == '0 && view_q && !wdata_i[DW-1])) |=> ferr_q); // R6
  AST_RXF_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
    (!rxf_o && !frm_vld_i) |=> !rxf_o); // R8
endmodule

bind mp_addr_filter mp_addr_filter_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .frm_vld_i(frm_vld_i), .frm_byte_i(frm_byte_i), .frm_bit9_i(frm_bit9_i),
  .frm_stop_i(frm_stop_i), .node_q(node_q), .mask_q(mask_q), .mp_en_q(mp_en_q),
  .ferr_q(ferr_q), .view_q(view_q), .rxf_o(rxf_o)
);

// File: tb/mp_addr_filter_test.sv
`timescale 1ns/1ps
module mp_addr_filter_test;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, fbyte = '0;
  logic fvld = 1'b0, fbit9 = 1'b0, fstop = 1'b1, rxf;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  mp_addr_filter #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .frm_vld_i(fvld), .frm_byte_i(fbyte), .frm_bit9_i(fbit9),
    .frm_stop_i(fstop), .rxf_o(rxf)
  );

  // {node, mask, byte, ninth bit, delivered}
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {8'hA5, 8'hFF, 8'hA5, 1'b1, 1'b1},
    {8'hA5, 8'hFF, 8'hA4, 1'b1, 1'b0},
    {8'hA5, 8'hFF, 8'hA5, 1'b0, 1'b0},
    {8'h30, 8'hF0, 8'h3C, 1'b1, 1'b1},
    {8'h30, 8'hF0, 8'h4C, 1'b1, 1'b0},
    {8'h30, 8'hF0, 8'hF7, 1'b1, 1'b1},
    {8'h01, 8'h0F, 8'h0F, 1'b1, 1'b1},
    {8'h01, 8'h0F, 8'h0E, 1'b1, 1'b0},
    {8'h00, 8'h00, 8'h77, 1'b1, 1'b1},
    {8'h00, 8'h00, 8'h77, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic frame(input logic [DW-1:0] b, input logic b9, input logic st);
    @(negedge clk); fvld = 1'b1; fbyte = b; fbit9 = b9; fstop = st;
    @(negedge clk); fvld = 1'b0; fstop = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [DW-1:0] d, prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 5; a++) begin
      rd(AW'(a), d); check($sformatf("R1 reg %0d", a), d, 8'h00);
    end
    check("R1 rxf_o", {7'b0, rxf}, 8'h00);
    rd(3'd5, d); check("R10 addr 5", d, 8'h00);
    rd(3'd7, d); check("R10 addr 7", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(3'd1, VEC[i][25:18]);
      wr(3'd2, VEC[i][17:10]);
      wr(3'd0, 8'h20);
      rd(3'd4, prev);
      frame(VEC[i][9:2], VEC[i][1], 1'b1);
      check($sformatf("R3/R4/R5 vec %0d flag", i), {7'b0, rxf}, {7'b0, VEC[i][0]});
      rd(3'd4, d);
      check($sformatf("R3/R4/R5 vec %0d data", i), d, VEC[i][0] ? VEC[i][9:2] : prev);
    end

    wr(3'd0, 8'h00);
    frame(8'h5A, 1'b0, 1'b1);
    check("R2 flag", {7'b0, rxf}, 8'h01);
    rd(3'd4, d); check("R2 data", d, 8'h5A);
    rd(3'd0, d); check("R9 ninth bit 0", d, 8'h01);
    frame(8'hC3, 1'b1, 1'b1);
    rd(3'd0, d); check("R9 ninth bit 1", d, 8'h03);
    rd(3'd4, d); check("R2 data 2", d, 8'hC3);

    wr(3'd0, 8'h00);
    check("R8 clear", {7'b0, rxf}, 8'h00);
    wr(3'd0, 8'h01);
    check("R8 write 1 no set", {7'b0, rxf}, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd0; wdata = 8'h00;
    fvld = 1'b1; fbyte = 8'h99; fbit9 = 1'b0; fstop = 1'b1;
    @(negedge clk); wr_en = 1'b0; fvld = 1'b0;
    check("R8 frame beats clear", {7'b0, rxf}, 8'h01);

    frame(8'h11, 1'b0, 1'b0);
    rd(3'd0, d); check("R7 view0 shows mode", {7'b0, d[7]}, 8'h00);
    wr(3'd3, 8'h01);
    rd(3'd0, d); check("R6 ferr set", {7'b0, d[7]}, 8'h01);
    frame(8'h22, 1'b0, 1'b1);
    rd(3'd0, d); check("R6 ferr sticky", {7'b0, d[7]}, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd0, d); check("R6 ferr cleared", {7'b0, d[7]}, 8'h00);

    wr(3'd3, 8'h00);
    wr(3'd0, 8'h80);
    rd(3'd0, d); check("R7 mode set", {7'b0, d[7]}, 8'h01);
    frame(8'h33, 1'b0, 1'b0);
    wr(3'd0, 8'h00);
    rd(3'd0, d); check("R7 mode cleared", {7'b0, d[7]}, 8'h00);
    wr(3'd3, 8'h01);
    rd(3'd0, d); check("R7 ferr kept by mode write", {7'b0, d[7]}, 8'h01);
    wr(3'd0, 8'h80);
    wr(3'd3, 8'h00);
    rd(3'd0, d); check("R7 mode kept by view write", {7'b0, d[7]}, 8'h00);
    rd(3'd3, d); check("R10 aux readback", d, 8'h00);

    finish_up();
  end
endmodule